// File: doc/BRIEF.md
# Strap-Sampling Suspend Indicator Pin Controller

This block owns one bidirectional pad that has two jobs. For a fixed window after reset is released, the pad is left undriven. An external pull resistor on the pad sets a configuration strap, and the block reads it. A low strap selects individual power switching and a high strap selects ganged power switching. The block stores that choice and presents it to the rest of the chip for as long as reset stays released.

When the window ends, the block turns the pad into an output that shows whether the chip is globally suspended. The polarity of the indicator follows the stored strap. The board therefore sees a level that is opposite to the strap resistor while the chip runs normally, and a level that matches the strap while it is suspended. This keeps the suspend indicator from fighting the strap pull.

The window length comes from the reference clock rate and a duration in microseconds. The defaults give 12 MHz and 1 ms, which is 12000 cycles. The strap is read several times near the end of the window, and a majority vote makes the decision. The suspend request comes from another clock domain and passes through a two-flop synchroniser.

Top module: `strap_susp_pin`

## Requirements
- R1: After reset is released, `padOe` stays 0 for exactly WIN_CYC rising edges, where WIN_CYC = CLK_KHZ*WINDOW_US/1000. It is 1 from the WIN_CYC-th edge on, until the next reset.
- R2: While `padOe` is 0, `padOut` is 0.
- R3: The strap is read on VOTES edges after release: edge WIN_CYC-1, and then every SPACING edges earlier. `gangMode` takes the majority of those readings. A pad value of 1 means gang mode (`gangMode`=1) and 0 means individual mode (`gangMode`=0).
- R4: `gangMode` reads 0 from reset until the window ends.
- R5: Once the window has ended, `gangMode` holds its value until the next reset, whatever `padIn` does.
- R6: In gang mode, with `padOe`=1, `padOut` is 1 while suspended and 0 during normal operation.
- R7: In individual mode, with `padOe`=1, `padOut` is 0 while suspended and 1 during normal operation.
- R8: A change on `suspendIn` reaches `padOut` on the second rising edge that samples it, and not on the first.
- R9: Asserting `rstN` low clears `padOe` and `gangMode` at once, without a clock. The next release starts a new window and a new strap decision.
- R10: Pad values on edges other than the R3 sampling edges have no effect on the decided mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (CLK_KHZ) |
| rstN | input | 1 | Asynchronous active-low reset |
| suspendIn | input | 1 | Global suspend request, 1 = suspended, asynchronous |
| padIn | input | 1 | Value read back from the pad |
| padOe | output | 1 | Pad output enable, 1 = drive |
| padOut | output | 1 | Value driven onto the pad |
| gangMode | output | 1 | Latched strap, 1 = gang, 0 = individual |

## Verification
The output enable and the mode both change on the WIN_CYC-th edge after release, so the bench counts edges from the release and compares each one against the expected window state. A suspend value driven before edge i shows on `padOut` after edge i+1. The bench keeps the last two driven values and compares against the older one. All checks are taken on the falling edge, half a period after the edge that made the change, so no comparison races a register update. The asynchronous clear is checked one time step after reset falls, before any clock edge.

// File: rtl/strap_susp_pkg.sv
package strap_susp_pkg;

  typedef struct packed {
    logic sampleStb;
    logic decideStb;
    logic windowOpen;
  } ctrlStb_t;

  function automatic logic majorityOf(input logic [31:0] bits, input int unsigned count);
    int unsigned ones;
    ones = 0;
    for (int unsigned i = 0; i < 32; i++) begin
      if (i < count && bits[i]) ones++;
    end
    return (2 * ones) > count;
  endfunction

endpackage

// File: rtl/strap_susp_ctrl.sv
module strap_susp_ctrl
  import strap_susp_pkg::*;
#(
  parameter int unsigned WIN_CYC = 12000,
  parameter int unsigned VOTES   = 3,
  parameter int unsigned SPACING = 4
) (
  input  logic     clk,
  input  logic     rstN,
  output ctrlStb_t stb
);
  localparam int unsigned CNT_W = $clog2(WIN_CYC + 1);
  localparam int unsigned LAST_SAMPLE = WIN_CYC - 2;

  logic [CNT_W-1:0] winCnt;
  logic [VOTES-1:0] sampleHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
    end else if (winCnt != CNT_W'(WIN_CYC)) begin
      winCnt <= winCnt + 1'b1;
    end
  end

  for (genvar k = 0; k < VOTES; k++) begin : g_sample
    assign sampleHit[k] = (winCnt == CNT_W'(LAST_SAMPLE - k * SPACING));
  end

  always_comb begin
    stb.sampleStb  = |sampleHit;
    stb.decideStb  = (winCnt == CNT_W'(WIN_CYC - 1));
    stb.windowOpen = (winCnt != CNT_W'(WIN_CYC));
  end
endmodule

// File: rtl/strap_susp_dp.sv
module strap_susp_dp
  import strap_susp_pkg::*;
#(
  parameter int unsigned VOTES = 3
) (
  input  logic     clk,
  input  logic     rstN,
  input  ctrlStb_t stb,
  input  logic     padIn,
  input  logic     suspendIn,
  output logic     padOe,
  output logic     padOut,
  output logic     gangMode
);
  logic [VOTES-1:0] voteQ;
  logic             gangQ;
  logic             oeQ;
  logic             suspMeta;
  logic             suspSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      voteQ <= '0;
    end else if (stb.sampleStb) begin
      voteQ <= (voteQ << 1) | VOTES'(padIn);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gangQ <= 1'b0;
      oeQ   <= 1'b0;
    end else if (stb.decideStb) begin
      gangQ <= majorityOf(32'(voteQ), VOTES);
      oeQ   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      suspMeta <= 1'b0;
      suspSync <= 1'b0;
    end else begin
      suspMeta <= suspendIn;
      suspSync <= suspMeta;
    end
  end

  assign padOe    = oeQ;
  assign gangMode = gangQ;
  assign padOut   = oeQ & ~(suspSync ^ gangQ);
endmodule

// File: rtl/strap_susp_pin.sv
module strap_susp_pin
  import strap_susp_pkg::*;
#(
  parameter int unsigned CLK_KHZ   = 12000,
  parameter int unsigned WINDOW_US = 1000,
  parameter int unsigned VOTES     = 3,
  parameter int unsigned SPACING   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic suspendIn,
  input  logic padIn,
  output logic padOe,
  output logic padOut,
  output logic gangMode
);
  localparam int unsigned WIN_CYC = CLK_KHZ * WINDOW_US / 1000;

  ctrlStb_t stb;

  strap_susp_ctrl #(.WIN_CYC(WIN_CYC), .VOTES(VOTES), .SPACING(SPACING)) u_ctrl (
    .clk (clk),
    .rstN(rstN),
    .stb (stb)
  );

  strap_susp_dp #(.VOTES(VOTES)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .padIn    (padIn),
    .suspendIn(suspendIn),
    .padOe    (padOe),
    .padOut   (padOut),
    .gangMode (gangMode)
  );
endmodule

// File: rtl/strap_susp_chk.sv
module strap_susp_chk #(
  parameter int unsigned CLK_KHZ   = 12000,
  parameter int unsigned WINDOW_US = 1000
) (
  input logic clk,
  input logic rstN,
  input logic suspendIn,
  input logic padIn,
  input logic padOe,
  input logic padOut,
  input logic gangMode
);
  localparam int unsigned WIN = CLK_KHZ * WINDOW_US / 1000;
  localparam int unsigned CW  = $clog2(WIN + 1);

  logic [CW-1:0] edgeCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeCnt <= '0;
    else if (edgeCnt != CW'(WIN)) edgeCnt <= edgeCnt + 1'b1;
  end

  a_r1_oe_low_in_window: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt != CW'(WIN)) |-> !padOe);

  a_r1_oe_high_after: assert property (@(posedge clk) disable iff (!rstN)
    (edgeCnt == CW'(WIN)) |-> padOe);

  a_r2_quiet_when_undriven: assert property (@(posedge clk) disable iff (!rstN)
    !padOe |-> !padOut);

  a_r4_mode_clear_in_window: assert property (@(posedge clk) disable iff (!rstN)
    !padOe |-> !gangMode);

  a_r5_mode_held: assert property (@(posedge clk) disable iff (!rstN)
    (padOe && $past(padOe)) |-> $stable(gangMode));

  a_r6_gang_polarity: assert property (@(posedge clk) disable iff (!rstN)
    (padOe && $past(padOe, 2) && gangMode) |-> (padOut == $past(suspendIn, 2)));

  a_r7_indiv_polarity: assert property (@(posedge clk) disable iff (!rstN)
    (padOe && $past(padOe, 2) && !gangMode) |-> (padOut != $past(suspendIn, 2)));
endmodule

bind strap_susp_pin strap_susp_chk #(.CLK_KHZ(CLK_KHZ), .WINDOW_US(WINDOW_US)) u_chk (
  .clk(clk), .rstN(rstN), .suspendIn(suspendIn), .padIn(padIn),
  .padOe(padOe), .padOut(padOut), .gangMode(gangMode)
);

// File: tb/strap_susp_pin_tb.sv
module strap_susp_pin_tb;
  localparam int unsigned CLK_KHZ   = 40;
  localparam int unsigned WINDOW_US = 1000;
  localparam int unsigned VOTES     = 3;
  localparam int unsigned SPACING   = 4;
  localparam int unsigned WIN       = CLK_KHZ * WINDOW_US / 1000;

  logic clk = 1'b0;
  logic rstN, suspendIn, padIn;
  logic padOe, padOut, gangMode;
  int   nRun = 0;
  int   nFail = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;

  strap_susp_pin #(.CLK_KHZ(CLK_KHZ), .WINDOW_US(WINDOW_US), .VOTES(VOTES), .SPACING(SPACING)) u_dut (
    .clk(clk), .rstN(rstN), .suspendIn(suspendIn), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .gangMode(gangMode)
  );

  task automatic check(input bit ok, input string req, input logic act, input logic exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit maj3(input bit [2:0] v);
    return (32'(v[0]) + 32'(v[1]) + 32'(v[2])) >= 2;
  endfunction

  // pad value for edge e after release: vote bits on sampling edges, disagreeing noise elsewhere
  function automatic bit padFor(input int e, input bit [2:0] v);
    for (int k = 0; k < 3; k++)
      if (e == int'(WIN) - 1 - k * int'(SPACING)) return v[k];
    return ~maj3(v);
  endfunction

  task automatic resetNow();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check(padOe == 1'b0, "R9 oe clear", padOe, 1'b0);
    check(gangMode == 1'b0, "R9 mode clear", gangMode, 1'b0);
    @(negedge clk);
  endtask

  task automatic runWindow(input bit [2:0] v, input int abortAt);
    bit expM;
    expM = maj3(v);
    resetNow();
    rstN = 1'b1;
    for (int e = 1; e <= int'(WIN); e++) begin
      padIn = padFor(e, v);
      suspendIn = 1'($urandom);
      @(posedge clk);
      @(negedge clk);
      if (e == abortAt) return;
      if (e < int'(WIN)) begin
        if (padOe !== 1'b0) check(1'b0, "R1 oe in window", padOe, 1'b0);
        if (padOut !== 1'b0) check(1'b0, "R2 out in window", padOut, 1'b0);
        if (gangMode !== 1'b0) check(1'b0, "R4 mode in window", gangMode, 1'b0);
      end
    end
    check(padOe == 1'b1, "R1 oe after window", padOe, 1'b1);
    check(gangMode == expM, "R3 R10 strap majority", gangMode, expM);
  endtask

  task automatic runSuspend(input int n);
    bit m, last, prev, d, expO;
    m = gangMode;
    suspendIn = 1'b0;
    @(negedge clk);
    @(negedge clk);
    last = 1'b0;
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      expO = m ? prev : ~prev;
      check(padOut == expO, m ? "R6 gang polarity" : "R7 individual polarity", padOut, expO);
      check(gangMode == m, "R5 mode held", gangMode, m);
      d = 1'($urandom);
      suspendIn = d;
      padIn = 1'($urandom);
      prev = last;
      last = d;
      @(negedge clk);
    end
  endtask

  task automatic pulseLatency();
    bit m;
    m = gangMode;
    suspendIn = 1'b0;
    repeat (3) @(negedge clk);
    suspendIn = 1'b1;
    @(negedge clk);
    suspendIn = 1'b0;
    check(padOut == ~m, "R8 one edge no change", padOut, ~m);
    @(negedge clk);
    check(padOut == m, "R8 two edges change", padOut, m);
    @(negedge clk);
    check(padOut == ~m, "R8 pulse ends", padOut, ~m);
  endtask

  initial begin
    void'($urandom(32'd5150));
    rstN = 1'b0;
    suspendIn = 1'b0;
    padIn = 1'b0;
    repeat (3) @(negedge clk);
    check(padOe == 1'b0, "R1 reset oe", padOe, 1'b0);
    check(padOut == 1'b0, "R2 reset out", padOut, 1'b0);
    check(gangMode == 1'b0, "R4 reset mode", gangMode, 1'b0);

    runWindow(3'b111, 0);  runSuspend(40); pulseLatency();
    runWindow(3'b000, 0);  runSuspend(40); pulseLatency();
    runWindow(3'b101, 0);  runSuspend(30);
    runWindow(3'b010, 0);  runSuspend(30);
    // R9: abort a gang window mid-way, then decide individual
    runWindow(3'b111, int'(WIN) / 2);
    runWindow(3'b100, 0);  runSuspend(20);
    for (int r = 0; r < 8; r++) begin
      runWindow(3'($urandom), 0);
      runSuspend(30);
    end
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule